// File: doc/BRIEF.md
# Dual-Plane Configuration Switch Controller

The controller keeps two banks of configuration words, called planes. One plane is active: its words are presented on a read port to the fabric that is executing the current function. The other plane is the shadow. While the active plane keeps running, a loader writes the next likely configuration into the shadow plane, one word per cycle. When the loader has finished, it marks the shadow complete.

A switch request then exchanges the two planes in one clock cycle. A one-bit plane pointer toggles, and the plane that was active becomes the new load target. Each plane also stores a preserve mask with one bit per datapath register. In the cycle after a swap, every register whose bit in the new active plane's mask is clear receives an init pulse. Registers whose bit is set keep their state.

The control is a two-state machine. LOADING means the shadow is not yet complete. ARMED means the shadow is complete and a swap is allowed. Its transitions are:
- mark_done: LOADING to ARMED, taken when ld_done is high.
- reopen: ARMED to LOADING, taken on a shadow write without ld_done.
- swap: ARMED to LOADING, taken on sw_req.
- refuse: LOADING to LOADING, taken on sw_req. It sets the refusal flag.

Top module: `cfg_plane_switch`

## Requirements
- R1: After reset, active_plane is 0, shadow_ready, sw_refused and sw_ack are 0, init_pulse is all zeros, and every configuration word and every mask in both planes reads 0.
- R2: A write with ld_valid=1 outside a swap cycle stores into the shadow plane. With ld_mask=0 it stores ld_data at word ld_addr. With ld_mask=1 it stores ld_data[NREG-1:0] as the shadow preserve mask. rd_data of the active plane is unchanged by it.
- R3: ld_done=1 outside a swap cycle makes shadow_ready 1 from the next cycle. A later write with ld_valid=1 and ld_done=0 makes it 0 from the next cycle. A write together with ld_done leaves it 1.
- R4: sw_req=1 while shadow_ready=1 toggles active_plane at that clock edge. After that edge, shadow_ready is 0 and sw_ack is 1 for exactly one cycle.
- R5: sw_req=1 while shadow_ready=0 leaves active_plane unchanged and sets sw_refused from the next cycle. sw_refused stays 1 until the next accepted swap clears it.
- R6: A write on the cycle of an accepted swap stores into the plane that was active before that edge, which is the new shadow. The plane that becomes active is unchanged by it.
- R7: ld_done on the cycle of an accepted swap is ignored: shadow_ready is 0 after the swap.
- R8: In the cycle after an accepted swap, init_pulse equals the bitwise inverse of the new active plane's preserve mask. In every other cycle it is all zeros.
- R9: rd_data is combinationally the word at rd_addr of the plane selected by active_plane, so it follows a swap in the cycle right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Shadow write strobe |
| ld_mask | input | 1 | 1: write goes to the preserve mask; 0: write goes to a configuration word |
| ld_addr | input | ADDR_W | Word address of the shadow write |
| ld_data | input | DATA_W | Write data; the low NREG bits are used for a mask write |
| ld_done | input | 1 | Marks the shadow plane complete |
| sw_req | input | 1 | Request to swap the planes |
| sw_ack | output | 1 | One-cycle pulse after an accepted swap |
| sw_refused | output | 1 | Set by a refused request; cleared by the next accepted swap |
| shadow_ready | output | 1 | Shadow plane marked complete (state ARMED) |
| active_plane | output | 1 | Plane pointer: index of the active plane |
| rd_addr | input | ADDR_W | Read address into the active plane |
| rd_data | output | DATA_W | Active configuration word at rd_addr |
| init_pulse | output | NREG | One-cycle init strobe for each register that is not preserved |

## Verification
A swap can coincide with a shadow write and with a completion mark. The bench raises sw_req, ld_valid and ld_done in the same cycle on an armed shadow. It then checks three things:
- The written word lands in the plane that was active until that edge, which is only visible once a second swap brings that plane back.
- The newly active plane's contents are unchanged.
- shadow_ready is low afterwards, so the completion mark was dropped.

A refused request is also placed between two loads, and the bench confirms that the refusal flag survives until the next accepted swap.

// File: rtl/cfg_plane_pkg.sv
package cfg_plane_pkg;

    // Control state: shadow still being filled, or shadow complete
    typedef enum logic [0:0] {
        ST_LOADING = 1'b0,
        ST_ARMED   = 1'b1
    } sw_state_e;

    localparam int unsigned NUM_PLANES = 2;

endpackage

// File: rtl/cfg_plane_store.sv
module cfg_plane_store
    import cfg_plane_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_mask,
    input  logic              wr_plane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_plane,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              keep_plane,
    output logic [NREG-1:0]   keep_out
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [NUM_PLANES-1:0][DATA_W-1:0] plane_word;
    logic [NUM_PLANES-1:0][NREG-1:0]   plane_keep;

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        logic [DATA_W-1:0] words [DEPTH];
        logic [NREG-1:0]   keep_q;
        logic              hit;

        assign hit = wr_en && (wr_plane == 1'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    words[i] <= '0;
                end
                keep_q <= '0;
            end else if (hit) begin
                if (wr_mask) begin
                    keep_q <= wr_data[NREG-1:0];
                end else begin
                    words[wr_addr] <= wr_data;
                end
            end
        end

        assign plane_word[p] = words[rd_addr];
        assign plane_keep[p] = keep_q;
    end

    assign rd_data  = plane_word[rd_plane];
    assign keep_out = plane_keep[keep_plane];

endmodule

// File: rtl/cfg_switch_fsm.sv
module cfg_switch_fsm
    import cfg_plane_pkg::*;
#(
    parameter int unsigned NREG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_valid,
    input  logic            ld_done,
    input  logic            sw_req,
    input  logic [NREG-1:0] shadow_keep,
    output sw_state_e       state_o,
    output logic            ptr_o,
    output logic            swap_now,
    output logic            refused_o,
    output logic            ack_o,
    output logic [NREG-1:0] init_o
);

    sw_state_e state_q;
    sw_state_e state_d;
    logic      refuse_now;

    assign swap_now   = (state_q == ST_ARMED)   && sw_req;
    assign refuse_now = (state_q == ST_LOADING) && sw_req;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOADING: begin
                // mark_done; a request here is the refuse transition
                if (ld_done) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (sw_req) begin
                    // swap: the old active plane becomes the load target
                    state_d = ST_LOADING;
                end else if (ld_valid && !ld_done) begin
                    // reopen: the shadow was touched after completion
                    state_d = ST_LOADING;
                end
            end
            default: state_d = ST_LOADING;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOADING;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_o     <= 1'b0;
            refused_o <= 1'b0;
            ack_o     <= 1'b0;
            init_o    <= '0;
        end else begin
            ack_o  <= swap_now;
            init_o <= swap_now ? ~shadow_keep : '0;
            if (swap_now) begin
                ptr_o     <= ~ptr_o;
                refused_o <= 1'b0;
            end else if (refuse_now) begin
                refused_o <= 1'b1;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/cfg_plane_switch.sv
module cfg_plane_switch
    import cfg_plane_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_mask,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_done,
    input  logic              sw_req,
    output logic              sw_ack,
    output logic              sw_refused,
    output logic              shadow_ready,
    output logic              active_plane,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NREG-1:0]   init_pulse
);

    sw_state_e       state;
    logic            ptr;
    logic            swap_now;
    logic            wr_plane;
    logic [NREG-1:0] shadow_keep;

    // On a swap edge the write follows the plane that becomes shadow
    assign wr_plane = swap_now ? ptr : ~ptr;

    cfg_switch_fsm #(
        .NREG (NREG)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_done     (ld_done),
        .sw_req      (sw_req),
        .shadow_keep (shadow_keep),
        .state_o     (state),
        .ptr_o       (ptr),
        .swap_now    (swap_now),
        .refused_o   (sw_refused),
        .ack_o       (sw_ack),
        .init_o      (init_pulse)
    );

    cfg_plane_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ld_valid),
        .wr_mask    (ld_mask),
        .wr_plane   (wr_plane),
        .wr_addr    (ld_addr),
        .wr_data    (ld_data),
        .rd_plane   (ptr),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .keep_plane (~ptr),
        .keep_out   (shadow_keep)
    );

    assign shadow_ready = (state == ST_ARMED);
    assign active_plane = ptr;

endmodule

// File: rtl/cfg_plane_switch_chk.sv
module cfg_plane_switch_chk #(
    parameter int unsigned NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ld_valid,
    input logic            ld_done,
    input logic            sw_req,
    input logic            sw_ack,
    input logic            sw_refused,
    input logic            shadow_ready,
    input logic            active_plane,
    input logic [NREG-1:0] init_pulse
);

    // R4
    swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && shadow_ready) |=> (active_plane != $past(active_plane)) && sw_ack);

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ack |=> !sw_ack);

    // R5
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !shadow_ready) |=> $stable(active_plane) && sw_refused && !sw_ack);

    // R7
    done_on_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && shadow_ready) |=> !shadow_ready);

    // R3
    ready_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_ready && ld_valid && !ld_done && !sw_req) |=> !shadow_ready);

    // R8
    init_after_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_pulse != '0) |-> sw_ack);

endmodule

bind cfg_plane_switch cfg_plane_switch_chk #(.NREG(NREG)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_valid     (ld_valid),
    .ld_done      (ld_done),
    .sw_req       (sw_req),
    .sw_ack       (sw_ack),
    .sw_refused   (sw_refused),
    .shadow_ready (shadow_ready),
    .active_plane (active_plane),
    .init_pulse   (init_pulse)
);

// File: tb/cfg_plane_switch_tb_top.sv
module cfg_plane_switch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int NREG   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic              ld_mask = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [DATA_W-1:0] ld_data = '0;
    logic              ld_done = 1'b0;
    logic              sw_req = 1'b0;
    logic              sw_ack;
    logic              sw_refused;
    logic              shadow_ready;
    logic              active_plane;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NREG-1:0]   init_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_plane_switch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_valid     (ld_valid),
        .ld_mask      (ld_mask),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .ld_done      (ld_done),
        .sw_req       (sw_req),
        .sw_ack       (sw_ack),
        .sw_refused   (sw_refused),
        .shadow_ready (shadow_ready),
        .active_plane (active_plane),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .init_pulse   (init_pulse)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        ld_valid = 1'b0; ld_mask = 1'b0; ld_done = 1'b0; sw_req = 1'b0;
    endtask

    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic done);
        ld_valid = 1'b1; ld_mask = 1'b0; ld_addr = a; ld_data = d; ld_done = done;
        tick();
        idle_inputs();
    endtask

    task automatic wr_keep(input logic [NREG-1:0] m);
        ld_valid = 1'b1; ld_mask = 1'b1; ld_data = DATA_W'(m);
        tick();
        idle_inputs();
    endtask

    task automatic mark_done();
        ld_done = 1'b1;
        tick();
        idle_inputs();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        rd_addr = 4'd3;
        #1;
        check("R1 active_plane", 64'(active_plane), 64'd0);
        check("R1 shadow_ready", 64'(shadow_ready), 64'd0);
        check("R1 sw_refused", 64'(sw_refused), 64'd0);
        check("R1 sw_ack", 64'(sw_ack), 64'd0);
        check("R1 init_pulse", 64'(init_pulse), 64'd0);
        check("R1 rd_data", 64'(rd_data), 64'd0);
    endtask

    task automatic t_load_and_refuse();
        wr_word(4'd3, 32'hA1A1_0003, 1'b0);
        rd_addr = 4'd3;
        #1;
        check("R2 active word untouched", 64'(rd_data), 64'd0);
        check("R3 not ready while loading", 64'(shadow_ready), 64'd0);
        sw_req = 1'b1;
        tick();
        idle_inputs();
        check("R5 plane kept on refusal", 64'(active_plane), 64'd0);
        check("R5 refusal flag set", 64'(sw_refused), 64'd1);
        check("R5 no ack on refusal", 64'(sw_ack), 64'd0);
        tick();
        check("R5 refusal flag sticky", 64'(sw_refused), 64'd1);
    endtask

    task automatic t_done_rules();
        wr_keep(8'hA5);
        wr_word(4'd5, 32'hB5B5_0005, 1'b1);
        check("R3 ready after write with done", 64'(shadow_ready), 64'd1);
        wr_word(4'd6, 32'hB6B6_0006, 1'b0);
        check("R3 ready cleared by later write", 64'(shadow_ready), 64'd0);
        mark_done();
        check("R3 ready after done", 64'(shadow_ready), 64'd1);
        check("R2 active plane still zero", 64'(rd_data), 64'd0);
    endtask

    task automatic t_swap_with_write();
        // swap, shadow write and done all in one cycle
        sw_req = 1'b1; ld_valid = 1'b1; ld_mask = 1'b0; ld_addr = 4'd3;
        ld_data = 32'hC3C3_0003; ld_done = 1'b1;
        tick();
        idle_inputs();
        rd_addr = 4'd3;
        #1;
        check("R4 plane toggled", 64'(active_plane), 64'd1);
        check("R4 ack high", 64'(sw_ack), 64'd1);
        check("R7 done ignored on swap", 64'(shadow_ready), 64'd0);
        check("R5 refusal cleared by swap", 64'(sw_refused), 64'd0);
        check("R8 init is inverse of keep mask", 64'(init_pulse), 64'h5A);
        check("R6 new active not hit by swap write", 64'(rd_data), 64'hA1A1_0003);
        rd_addr = 4'd5;
        #1;
        check("R9 read follows new plane", 64'(rd_data), 64'hB5B5_0005);
        tick();
        check("R4 ack single cycle", 64'(sw_ack), 64'd0);
        check("R8 init single cycle", 64'(init_pulse), 64'd0);
    endtask

    task automatic t_swap_back();
        mark_done();
        sw_req = 1'b1;
        tick();
        idle_inputs();
        rd_addr = 4'd3;
        #1;
        check("R4 plane toggled back", 64'(active_plane), 64'd0);
        check("R6 swap write landed in old active", 64'(rd_data), 64'hC3C3_0003);
        check("R8 unwritten mask inits all", 64'(init_pulse), 64'hFF);
        mark_done();
        sw_req = 1'b1;
        tick();
        idle_inputs();
        #1;
        check("R6 other plane kept its word", 64'(rd_data), 64'hA1A1_0003);
        check("R8 stored keep mask reused", 64'(init_pulse), 64'h5A);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_load_and_refuse();
        t_done_rules();
        t_swap_with_write();
        t_swap_back();
        tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule